// File: doc/BRIEF.md
# PLL Divider Ratio Solver

This block turns a requested output-to-reference frequency ratio into settings for a fractional-free PLL. A PLL of this kind has a feedback multiplier, an input pre-divider and a power-of-two output divider. Given a target rate as the numerator and a reference rate as the denominator, the block looks for the best fraction with a small numerator and denominator. It then scales that fraction into the multiplier's legal range, moves the power-of-two part of the denominator into the output divider, and checks the range of all three values. It also produces the packed register codes that the PLL configuration interface expects.

The search is a continued-fraction expansion. Each partial quotient comes from one shared sequential divider that handles one division at a time. A one-cycle start pulse launches a computation. A one-cycle done pulse ends it, together with the three raw settings, their register codes and an error flag. The results stay stable until the next computation finishes.

Top module: `pll_ratio_solver`

## Requirements
- R1: Starting from the convergents 0/1 (older) and 1/0 (current), each step divides a by b to get quotient q and remainder r. It forms the candidate older + current·q for numerator and denominator, then shifts older←current, current←candidate, a←b, b←r. The search ends with the current convergent once the remainder b is zero (1000/24 gives 125/3).
- R2: If a candidate's numerator exceeds 255 or its denominator exceeds 256, the search stops at once and keeps the current convergent (355/113 gives 22/7).
- R3: A zero denominator at start reports an error, with done no more than 3 clock edges after the edge that samples start. A search that ends with a zero numerator or denominator reports an error.
- R4: While the numerator is below 16 and the denominator is at most 128, both are doubled (3/2 becomes 24/16).
- R5: With k the count of trailing zero bits of the denominator, capped at 3, the outputs are cmVal = numerator, cnVal = denominator >> k and coVal = 2^k.
- R6: err is set unless cmVal is in 16..255 and cnVal is in 1..32.
- R7: cmCode is 0xE0|(cm−16) for cm<32, 0xC0|(cm−32) for cm<64, 0x80|(cm−64) for cm<128, and cm−128 otherwise.
- R8: cnCode is 0x1F for cn=1 and otherwise bits [4:0] of 0xCB7A89C0 >> (cn−1). coCode is log2(coVal).
- R9: done is high for exactly one cycle per computation. When err is set, all three codes read zero.
- R10: A start pulse during a computation is ignored and does not change the result. Only one division runs at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (sampled when idle) |
| numIn | input | 32 | Target rate (ratio numerator) |
| denIn | input | 32 | Reference rate (ratio denominator) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Settings out of range or degenerate ratio |
| cmVal | output | 8 | Raw multiplier |
| cnVal | output | 9 | Raw pre-divider |
| coVal | output | 4 | Raw post-divider (1, 2, 4, 8) |
| cmCode | output | 8 | Encoded multiplier |
| cnCode | output | 5 | Encoded pre-divider |
| coCode | output | 2 | Encoded post-divider |

## Verification
The bench targets the truncation step, where 355/113 must fall back to 22/7. A design that kept the rejected candidate would report an error or a multiplier above the limit. It checks that 3/2 is doubled until the multiplier reaches 24 and that the post-divider is capped at 8 with a pre-divider of 2. An uncapped split would return a pre-divider of 1. It checks that a pre-divider of 33 and a multiplier of 1 raise err. It sends a zero denominator, a zero numerator and an early overflow (1000/1), each of which must end in an error with zeroed codes and not in a hang. It also sends a second start during a busy run, which a design with a loose idle check would restart on, giving the second ratio's settings.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;
  localparam int RW         = 9;     // convergent register width
  localparam int N_LIMIT    = 255;   // largest accepted numerator
  localparam int D_LIMIT    = 256;   // largest accepted denominator
  localparam int N_FLOOR    = 16;    // smallest legal multiplier
  localparam int D_GROW_MAX = 128;   // doubling allowed while den <= this
  localparam int K_CAP      = 3;     // post-divider exponent cap
  localparam int KW         = $clog2(K_CAP + 1);
  localparam int CN_MAX     = 32;
  localparam int CMW        = 8;
  localparam int COW        = K_CAP + 1;
  localparam int CNCW       = 5;
  localparam int COCW       = KW;
  localparam logic [31:0] CN_PATTERN = 32'hCB7A89C0;

  typedef struct packed {
    logic init;
    logic divStart;
    logic update;
    logic normStep;
    logic finish;
  } strobes_t;

  typedef struct packed {
    logic bZero;
    logic divDone;
    logic ovf;
    logic normNeed;
  } status_t;

  function automatic logic [CMW-1:0] cmEncode(input logic [CMW-1:0] cm);
    if (cm < 8'd32)       return 8'hE0 | (cm - 8'd16);
    else if (cm < 8'd64)  return 8'hC0 | (cm - 8'd32);
    else if (cm < 8'd128) return 8'h80 | (cm - 8'd64);
    else                  return cm - 8'd128;
  endfunction

  function automatic logic [CNCW-1:0] cnEncode(input logic [RW-1:0] cn);
    logic [RW-1:0] sh;
    logic [31:0]   shifted;
    sh = cn - RW'(1);
    shifted = CN_PATTERN >> sh[4:0];
    if (cn == RW'(1)) return 5'h1F;
    return shifted[CNCW-1:0];
  endfunction
endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic          doneP
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dvsr;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW:0]   shifted;
  logic          fits;

  always_comb begin
    shifted = {rem, quot[DW-1]};
    fits    = shifted >= {1'b0, dvsr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quot  <= '0;
      rem   <= '0;
      dvsr  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      doneP <= 1'b0;
    end else if (start) begin
      quot  <= dividend;
      rem   <= '0;
      dvsr  <= divisor;
      cnt   <= CW'(DW);
      busy  <= 1'b1;
      doneP <= 1'b0;
    end else if (busy) begin
      if (fits) begin
        rem  <= DW'(shifted - {1'b0, dvsr});
        quot <= {quot[DW-2:0], 1'b1};
      end else begin
        rem  <= shifted[DW-1:0];
        quot <= {quot[DW-2:0], 1'b0};
      end
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        busy  <= 1'b0;
        doneP <= 1'b1;
      end
    end else begin
      doneP <= 1'b0;
    end
  end

  // R10: never launch while a division is in flight
  a_r10_one_div: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);
  // R1: remainder is below the divisor on completion
  a_r1_rem_lt_div: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> rem < dvsr);
endmodule

// File: rtl/pll_ratio_ctrl.sv
module pll_ratio_ctrl
  import pll_ratio_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     denZero,
  input  status_t  stat,
  output strobes_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_DIV, S_NORM, S_FIN} state_t;
  state_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        stb.init  = 1'b1;
        nextState = denZero ? S_FIN : S_CHECK;
      end
      S_CHECK: if (stat.bZero) nextState = S_NORM;
               else begin
                 stb.divStart = 1'b1;
                 nextState    = S_DIV;
               end
      S_DIV: if (stat.divDone) begin
        stb.update = 1'b1;
        nextState  = stat.ovf ? S_NORM : S_CHECK;
      end
      S_NORM: if (stat.normNeed) stb.normStep = 1'b1;
              else nextState = S_FIN;
      S_FIN: begin
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R3: zero denominator goes straight to the finishing step
  a_r3_zero_den_fast: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && denZero) |=> state == S_FIN);
  // R10: a new computation can only be loaded from idle
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !stb.init);
endmodule

// File: rtl/pll_ratio_dp.sv
module pll_ratio_dp
  import pll_ratio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [DW-1:0]    numIn,
  input  logic [DW-1:0]    denIn,
  output status_t          stat,
  output logic             done,
  output logic             err,
  output logic [CMW-1:0]   cmVal,
  output logic [RW-1:0]    cnVal,
  output logic [COW-1:0]   coVal,
  output logic [CMW-1:0]   cmCode,
  output logic [CNCW-1:0]  cnCode,
  output logic [COCW-1:0]  coCode
);
  localparam int PW = DW + RW + 1;

  logic [DW-1:0] aReg, bReg, quot, rem;
  logic [RW-1:0] nOld, dOld, nCur, dCur;
  logic [PW-1:0] nNew, dNew;
  logic          divDone;
  logic [KW-1:0] k;
  logic [RW-1:0] cnRaw;
  logic [COW-1:0] coRaw;
  logic          errNow;

  pll_ratio_div #(.DW(DW)) uDiv (
    .clk(clk), .rstN(rstN), .start(stb.divStart),
    .dividend(aReg), .divisor(bReg),
    .quot(quot), .rem(rem), .doneP(divDone)
  );

  always_comb begin
    nNew = PW'(nOld) + PW'(nCur) * PW'(quot);
    dNew = PW'(dOld) + PW'(dCur) * PW'(quot);
    stat.bZero    = (bReg == '0);
    stat.divDone  = divDone;
    stat.ovf      = (nNew > PW'(N_LIMIT)) || (dNew > PW'(D_LIMIT));
    stat.normNeed = (nCur != '0) && (dCur != '0) &&
                    (nCur < RW'(N_FLOOR)) && (dCur <= RW'(D_GROW_MAX));
  end

  // post-divider split: lowest set bit among the low K_CAP bits
  always_comb begin
    k = KW'(K_CAP);
    for (int i = K_CAP - 1; i >= 0; i--)
      if (dCur[i]) k = KW'(i);
    cnRaw  = dCur >> k;
    coRaw  = COW'(1) << k;
    errNow = (nCur < RW'(N_FLOOR)) || (nCur > RW'(N_LIMIT)) ||
             (cnRaw == '0) || (cnRaw > RW'(CN_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0;
      nOld <= '0; dOld <= '0; nCur <= '0; dCur <= '0;
    end else if (stb.init) begin
      aReg <= numIn;    bReg <= denIn;
      nOld <= '0;       dOld <= RW'(1);
      nCur <= RW'(1);   dCur <= '0;
    end else if (stb.update && !stat.ovf) begin
      nOld <= nCur;     dOld <= dCur;
      nCur <= nNew[RW-1:0];
      dCur <= dNew[RW-1:0];
      aReg <= bReg;     bReg <= rem;
    end else if (stb.normStep) begin
      nCur <= nCur << 1;
      dCur <= dCur << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; err <= 1'b0;
      cmVal <= '0; cnVal <= '0; coVal <= '0;
      cmCode <= '0; cnCode <= '0; coCode <= '0;
    end else begin
      done <= stb.finish;
      if (stb.finish) begin
        err    <= errNow;
        cmVal  <= nCur[CMW-1:0];
        cnVal  <= cnRaw;
        coVal  <= coRaw;
        cmCode <= errNow ? '0 : cmEncode(nCur[CMW-1:0]);
        cnCode <= errNow ? '0 : cnEncode(cnRaw);
        coCode <= errNow ? '0 : COCW'(k);
      end
    end
  end

  // R2: the kept convergent never exceeds the limits
  a_r2_conv_bound: assert property (@(posedge clk) disable iff (!rstN)
    (nCur <= RW'(N_LIMIT)) && (dCur <= RW'(D_LIMIT)));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: a clean result is always in range
  a_r6_range_ok: assert property (@(posedge clk) disable iff (!rstN)
    (done && !err) |-> (cmVal >= CMW'(N_FLOOR)) && (cnVal >= RW'(1)) &&
                       (cnVal <= RW'(CN_MAX)) && ($countones(coVal) == 1));
  // R9: codes are cleared whenever an error is reported
  a_r9_err_codes: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (cmCode == '0) && (cnCode == '0) && (coCode == '0));
endmodule

// File: rtl/pll_ratio_solver.sv
module pll_ratio_solver
  import pll_ratio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DW-1:0]    numIn,
  input  logic [DW-1:0]    denIn,
  output logic             done,
  output logic             err,
  output logic [CMW-1:0]   cmVal,
  output logic [RW-1:0]    cnVal,
  output logic [COW-1:0]   coVal,
  output logic [CMW-1:0]   cmCode,
  output logic [CNCW-1:0]  cnCode,
  output logic [COCW-1:0]  coCode
);
  strobes_t stb;
  status_t  stat;

  pll_ratio_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .denZero(denIn == '0), .stat(stat), .stb(stb)
  );

  pll_ratio_dp #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .numIn(numIn), .denIn(denIn),
    .stat(stat), .done(done), .err(err),
    .cmVal(cmVal), .cnVal(cnVal), .coVal(coVal),
    .cmCode(cmCode), .cnCode(cnCode), .coCode(coCode)
  );
endmodule

// File: tb/pll_ratio_solver_test.sv
module pll_ratio_solver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] numIn = '0, denIn = '0;
  logic        done, err;
  logic [7:0]  cmVal, cmCode;
  logic [8:0]  cnVal;
  logic [3:0]  coVal;
  logic [4:0]  cnCode;
  logic [1:0]  coCode;

  int tests = 0, fails = 0, cyc = 0;
  int gErr, gCm, gCn, gCo, gCmc, gCnc, gCoc, gLat;

  pll_ratio_solver uut (
    .clk(clk), .rstN(rstN), .start(start), .numIn(numIn), .denIn(denIn),
    .done(done), .err(err), .cmVal(cmVal), .cnVal(cnVal), .coVal(coVal),
    .cmCode(cmCode), .cnCode(cnCode), .coCode(coCode)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam int NT = 7;
  localparam logic [31:0] tNum [NT] = '{1000, 3, 355, 16, 1, 0, 1000};
  localparam logic [31:0] tDen [NT] = '{24, 2, 113, 33, 200, 5, 1};
  localparam int tErr [NT] = '{0, 0, 0, 1, 1, 1, 1};
  localparam int tCm  [NT] = '{125, 24, 22, 0, 0, 0, 0};
  localparam int tCn  [NT] = '{3, 2, 7, 0, 0, 0, 0};
  localparam int tCo  [NT] = '{1, 8, 1, 0, 0, 0, 0};
  localparam int tCmc [NT] = '{'hBD, 'hE8, 'hE6, 0, 0, 0, 0};
  localparam int tCnc [NT] = '{'h10, 'h00, 'h07, 0, 0, 0, 0};
  localparam int tCoc [NT] = '{0, 3, 0, 0, 0, 0, 0};
  localparam string tReq [NT] = '{"R1", "R4 R5", "R2", "R6", "R6", "R3", "R3"};

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] n, input logic [31:0] d);
    @(negedge clk);
    numIn = n; denIn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    gLat = 1;
    while (!done && gLat < 5000) begin
      @(negedge clk);
      gLat++;
    end
    gErr = err; gCm = cmVal; gCn = cnVal; gCo = coVal;
    gCmc = cmCode; gCnc = cnCode; gCoc = coCode;
  endtask

  function automatic int expCmCode(input int cm);
    if (cm < 32) return 'hE0 | (cm - 16);
    if (cm < 64) return 'hC0 | (cm - 32);
    if (cm < 128) return 'h80 | (cm - 64);
    return cm - 128;
  endfunction

  function automatic int expCnCode(input int cn);
    if (cn == 1) return 'h1F;
    return int'((32'hCB7A89C0 >> (cn - 1)) & 32'h1F);
  endfunction

  // reference search built from R1..R6
  task automatic model(input longint num, input longint den,
                       output int eErr, output int eCm, output int eCn, output int eCo);
    longint a, b, q, r, no, dO, nc, dc, nn, dn;
    int k;
    a = num; b = den; no = 0; dO = 1; nc = 1; dc = 0;
    while (b != 0) begin
      q = a / b; nn = no + nc * q; dn = dO + dc * q;
      if (nn > 255 || dn > 256) break;
      no = nc; dO = dc; nc = nn; dc = dn;
      r = a - b * q; a = b; b = r;
    end
    if (nc != 0 && dc != 0)
      while (nc < 16 && dc <= 128) begin nc = nc * 2; dc = dc * 2; end
    k = 0;
    while (k < 3 && ((dc >> k) & 1) == 0) k++;
    eCm = int'(nc); eCn = int'(dc >> k); eCo = 1 << k;
    eErr = (eCm < 16 || eCm > 255 || eCn < 1 || eCn > 32) ? 1 : 0;
  endtask

  initial begin
    int mErr, mCm, mCn, mCo;
    repeat (3) @(negedge clk);
    // reset state
    check("R9", "reset done", done, 0);
    check("R9", "reset err", err, 0);
    check("R5", "reset cmVal", cmVal, 0);
    check("R8", "reset cnCode", cnCode, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table of hand-derived vectors
    for (int i = 0; i < NT; i++) begin
      launch(tNum[i], tDen[i]);
      waitDone();
      check(tReq[i], "done seen", done, 1);
      check(tReq[i], "err", gErr, tErr[i]);
      if (tErr[i] == 0) begin
        check(tReq[i], "cmVal", gCm, tCm[i]);
        check(tReq[i], "cnVal", gCn, tCn[i]);
        check(tReq[i], "coVal", gCo, tCo[i]);
        check("R7", "cmCode", gCmc, tCmc[i]);
        check("R8", "cnCode", gCnc, tCnc[i]);
        check("R8", "coCode", gCoc, tCoc[i]);
      end else begin
        check("R9", "err codes zero", gCmc + gCnc + gCoc, 0);
      end
      @(negedge clk);
      check("R9", "done one cycle", done, 0);
    end

    // zero denominator: immediate error
    launch(32'd500, 32'd0);
    waitDone();
    check("R3", "zero den err", gErr, 1);
    check("R3", "zero den latency", (gLat <= 2) ? 1 : 0, 1);

    // rate sweep against the reference search
    for (int j = 0; j < 20; j++) begin
      logic [31:0] n, d;
      n = 32'(80000000 + j * 71000000);
      d = (j % 2 == 0) ? 32'd24000000 : 32'd27000000;
      model(longint'(n), longint'(d), mErr, mCm, mCn, mCo);
      launch(n, d);
      waitDone();
      check("R1", "sweep err", gErr, mErr);
      if (mErr == 0) begin
        check("R5", "sweep cm", gCm, mCm);
        check("R5", "sweep cn", gCn, mCn);
        check("R5", "sweep co", gCo, mCo);
        check("R7", "sweep cmCode", gCmc, expCmCode(mCm));
        check("R8", "sweep cnCode", gCnc, expCnCode(mCn));
      end
    end

    // start during a busy run is ignored
    launch(32'd355, 32'd113);
    repeat (5) @(negedge clk);
    numIn = 32'd1000; denIn = 32'd24; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check("R10", "busy start cm", gCm, 22);
    check("R10", "busy start cn", gCn, 7);
    begin
      int extra = 0;
      @(negedge clk);
      repeat (300) begin
        if (done) extra++;
        @(negedge clk);
      end
      check("R10", "no second done", extra, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule